// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Data Unit

This block is the arithmetic datapath of a 16-bit signal-processing core. It holds three 16-bit source registers and two 36-bit accumulators. In one clock it can multiply two source registers or multiply-accumulate them, adding or subtracting the product. It can also add or subtract a register or the other accumulator, apply a bitwise AND, OR or XOR to the upper word, arithmetic-shift a register value through a 16-bit barrel shifter, or shift a whole accumulator by one bit. Each accumulator holds four guard bits above a 32-bit value. Sums can therefore run past full scale without wrapping. Clipping happens only at the read port, where a limiter turns the selected accumulator into a 16-bit word.

The surrounding core drives one operation per cycle on the op inputs. It loads registers and single accumulator fields through a separate write port. It reads results either as full 36-bit accumulator values or as the limited 16-bit word. The reset input is asserted asynchronously, and its release is synchronised to the clock, which takes two edges.

Top module: `fmac_unit`

## Requirements
- R1: While reset is asserted, and after it is released, both accumulators, all three source registers and the overflow flag read as zero.
- R2: When `wr_en` is high, the field picked by `wr_sel` takes `wr_data` at the clock edge and no other field changes. The encodings are: 0 X0, 1 Y0, 2 Y1, 4 A low word, 5 A upper word, 6 A guard bits (taken from `wr_data[3:0]`), 8 B low word, 9 B upper word, 10 B guard bits. Every other code writes nothing.
- R3: Op 0 (multiply) stores the signed product of the sources picked by `op_src_a` and `op_src_b` into the destination accumulator at the next edge. The source encodings are 0 X0, 1 Y0, 2 Y1 and 3 zero. With `op_frac` high the product is doubled. In both modes it is sign-extended to 36 bits.
- R4: Op 1 adds that product to the destination accumulator and op 2 subtracts it, in the same cycle.
- R5: Op 3 adds, and op 4 subtracts, source A placed in the upper word, with the low word zero and the guard bits sign-extended.
- R6: Op 5 adds the other accumulator to the destination, and op 6 subtracts it.
- R7: Ops 7, 8 and 9 replace the destination's upper word with its AND, OR or XOR with source A. The guard bits and the low word are unchanged.
- R8: Op 10 arithmetic-shifts source A right by `op_shamt`, and op 11 shifts it left, dropping the bits that leave 16 bits. The 16-bit result is placed in the upper word as in R5.
- R9: Op 12 doubles the destination accumulator. Op 13 halves it with an arithmetic right shift.
- R10: After ops 1–6 and 12, `ovf` is high exactly when the true result lies outside the signed 36-bit range; the stored value wraps. Every other valid op clears `ovf`, and ops 14 and 15 change nothing.
- R11: `rd_word` is bits 31:16 of the accumulator picked by `rd_sel` (0 A, 1 B) when that accumulator's value fits in signed 32 bits. Otherwise it is 0x7FFF for a positive value or 0x8000 for a negative one, and `rd_sat` is high. The read is combinational.
- R12: With `op_valid` and `wr_en` both low, no register and no flag changes.
- R13: When an op and a field write hit the same accumulator in one cycle, the op result is stored except for the written field, which takes `wr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Perform the op on this edge |
| op_code | input | 4 | Operation select |
| op_dst | input | 1 | Destination accumulator, 0 A, 1 B |
| op_src_a | input | 2 | First source register |
| op_src_b | input | 2 | Second multiplier source |
| op_frac | input | 1 | Fractional product scaling |
| op_shamt | input | 4 | Barrel shift amount |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 4 | Field write target |
| wr_data | input | 16 | Field write data |
| rd_sel | input | 1 | Limited read select |
| rd_word | output | 16 | Limited 16-bit read value |
| rd_sat | output | 1 | Read value was clipped |
| acc_a | output | 36 | Accumulator A |
| acc_b | output | 36 | Accumulator B |
| ovf | output | 1 | Last op overflowed 36 bits |

## Verification
The bench runs every opcode in both product modes over a grid of operand corners: 0, ±1, full-scale positive, the most negative value and half scale. It starts from accumulators sitting at or beyond the 32-bit limiter thresholds and at the 36-bit edges. The most negative value squared in fractional mode goes after a design that wraps the doubled product into the sign bit instead of carrying it into the guard bits. The accumulator edges catch an overflow flag taken from bit 31 rather than bit 35, and a missing carry-in on subtraction shows as results that are off by one. Reading each accumulator one step past ±2^31 exposes a limiter that checks only the guard bits and misses bit 31. A same-cycle write over an op result shows whether the write port merges per field or overwrites the whole accumulator.

// File: rtl/fmac_pkg.sv
`timescale 1ns/1ps
package fmac_pkg;

  typedef enum logic [3:0] {
    OP_MPY  = 4'd0,
    OP_MAC  = 4'd1,
    OP_MSU  = 4'd2,
    OP_ADDR = 4'd3,
    OP_SUBR = 4'd4,
    OP_ADDA = 4'd5,
    OP_SUBA = 4'd6,
    OP_AND  = 4'd7,
    OP_OR   = 4'd8,
    OP_XOR  = 4'd9,
    OP_ASR  = 4'd10,
    OP_ASL  = 4'd11,
    OP_ACCL = 4'd12,
    OP_ACCR = 4'd13
  } op_e;

  // write-select layout: [3:2] 0 source regs, 1 acc A, 2 acc B; [1:0] field
  localparam logic [1:0] FLD_LO  = 2'd0;
  localparam logic [1:0] FLD_HI  = 2'd1;
  localparam logic [1:0] FLD_EXT = 2'd2;

endpackage

// File: rtl/fmac_rst_sync.sv
`timescale 1ns/1ps
module fmac_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end

endmodule

// File: rtl/fmac_mult.sv
`timescale 1ns/1ps
module fmac_mult #(
  parameter int DW = 16,
  parameter int GW = 4
) (
  input  logic [DW-1:0]       a,
  input  logic [DW-1:0]       b,
  input  logic                frac,
  output logic [2*DW+GW-1:0]  prod
);

  localparam int AW = 2*DW + GW;

  logic signed [2*DW-1:0] raw;
  logic        [AW-1:0]   ext;

  assign raw  = $signed(a) * $signed(b);
  assign ext  = {{GW{raw[2*DW-1]}}, raw};
  // fractional scaling: one extra left shift into the guard field
  assign prod = frac ? {ext[AW-2:0], 1'b0} : ext;

endmodule

// File: rtl/fmac_addsub.sv
`timescale 1ns/1ps
module fmac_addsub #(
  parameter int AW = 36
) (
  input  logic [AW-1:0] x,
  input  logic [AW-1:0] y,
  input  logic          sub,
  output logic [AW-1:0] sum,
  output logic          ovf
);

  logic [AW:0] ex;
  logic [AW:0] ey;
  logic [AW:0] full;

  assign ex   = {x[AW-1], x};
  assign ey   = sub ? ~{y[AW-1], y} : {y[AW-1], y};
  assign full = ex + ey + {{AW{1'b0}}, sub};
  assign sum  = full[AW-1:0];
  assign ovf  = full[AW] ^ full[AW-1];

endmodule

// File: rtl/fmac_bshift.sv
`timescale 1ns/1ps
module fmac_bshift #(
  parameter int DW = 16
) (
  input  logic [DW-1:0]         din,
  input  logic [$clog2(DW)-1:0] amt,
  input  logic                  left,
  output logic [DW-1:0]         dout
);

  localparam int SW = $clog2(DW);

  logic [DW-1:0] stage [SW+1];

  assign stage[0] = din;

  for (genvar i = 0; i < SW; i++) begin : g_stage
    localparam int STEP = 2 ** i;
    logic [DW-1:0] moved;
    assign moved = left ? (stage[i] << STEP)
                        : DW'($signed(stage[i]) >>> STEP);
    assign stage[i+1] = amt[i] ? moved : stage[i];
  end

  assign dout = stage[SW];

endmodule

// File: rtl/fmac_limit.sv
`timescale 1ns/1ps
module fmac_limit #(
  parameter int DW = 16,
  parameter int GW = 4
) (
  input  logic [2*DW+GW-1:0] acc,
  output logic [DW-1:0]      word,
  output logic               sat
);

  localparam int AW = 2*DW + GW;

  logic [GW:0] top;
  logic        fits;

  assign top  = acc[AW-1:2*DW-1];
  assign fits = (&top) | ~(|top);
  assign sat  = ~fits;

  always_comb begin
    if (fits)            word = acc[2*DW-1:DW];
    else if (acc[AW-1])  word = {1'b1, {(DW-1){1'b0}}};
    else                 word = {1'b0, {(DW-1){1'b1}}};
  end

endmodule

// File: rtl/fmac_unit.sv
`timescale 1ns/1ps
module fmac_unit
  import fmac_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int GUARD_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          op_valid,
  input  logic [3:0]                    op_code,
  input  logic                          op_dst,
  input  logic [1:0]                    op_src_a,
  input  logic [1:0]                    op_src_b,
  input  logic                          op_frac,
  input  logic [$clog2(DATA_W)-1:0]     op_shamt,
  input  logic                          wr_en,
  input  logic [3:0]                    wr_sel,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic                          rd_sel,
  output logic [DATA_W-1:0]             rd_word,
  output logic                          rd_sat,
  output logic [2*DATA_W+GUARD_W-1:0]   acc_a,
  output logic [2*DATA_W+GUARD_W-1:0]   acc_b,
  output logic                          ovf
);

  localparam int AW   = 2*DATA_W + GUARD_W;
  localparam int NREG = 3;
  localparam int NACC = 2;

  logic rst_sync_n;

  logic [DATA_W-1:0] xr_q [NREG];
  logic [DATA_W-1:0] xr_n [NREG];
  logic [AW-1:0]     acc_q [NACC];
  logic [AW-1:0]     acc_n [NACC];
  logic              ovf_q, ovf_n;

  logic [DATA_W-1:0] opa, opb, shv;
  logic [AW-1:0]     dacc, oacc, upa, prod;
  logic [AW-1:0]     as_y, as_sum, res;
  logic              as_sub, as_ovf, res_ovf, res_upd;
  logic              acc_en, xr_en, ovf_en;

  fmac_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // operand selection
  always_comb begin
    case (op_src_a)
      2'd0:    opa = xr_q[0];
      2'd1:    opa = xr_q[1];
      2'd2:    opa = xr_q[2];
      default: opa = '0;
    endcase
    case (op_src_b)
      2'd0:    opb = xr_q[0];
      2'd1:    opb = xr_q[1];
      2'd2:    opb = xr_q[2];
      default: opb = '0;
    endcase
  end

  assign dacc = acc_q[op_dst];
  assign oacc = acc_q[~op_dst];
  assign upa  = {{GUARD_W{opa[DATA_W-1]}}, opa, {DATA_W{1'b0}}};

  fmac_mult #(.DW(DATA_W), .GW(GUARD_W)) u_mult (
    .a    (opa),
    .b    (opb),
    .frac (op_frac),
    .prod (prod)
  );

  fmac_bshift #(.DW(DATA_W)) u_shift (
    .din  (opa),
    .amt  (op_shamt),
    .left (op_code == OP_ASL),
    .dout (shv)
  );

  // adder second operand and direction
  always_comb begin
    as_y   = prod;
    as_sub = 1'b0;
    case (op_e'(op_code))
      OP_MSU:  as_sub = 1'b1;
      OP_ADDR: as_y = upa;
      OP_SUBR: begin as_y = upa;  as_sub = 1'b1; end
      OP_ADDA: as_y = oacc;
      OP_SUBA: begin as_y = oacc; as_sub = 1'b1; end
      OP_ACCL: as_y = dacc;
      default: ;
    endcase
  end

  fmac_addsub #(.AW(AW)) u_addsub (
    .x   (dacc),
    .y   (as_y),
    .sub (as_sub),
    .sum (as_sum),
    .ovf (as_ovf)
  );

  // operation result
  always_comb begin
    res     = dacc;
    res_ovf = 1'b0;
    res_upd = 1'b1;
    case (op_e'(op_code))
      OP_MPY: res = prod;
      OP_MAC, OP_MSU, OP_ADDR, OP_SUBR, OP_ADDA, OP_SUBA, OP_ACCL: begin
        res     = as_sum;
        res_ovf = as_ovf;
      end
      OP_AND: res[2*DATA_W-1:DATA_W] = dacc[2*DATA_W-1:DATA_W] & opa;
      OP_OR:  res[2*DATA_W-1:DATA_W] = dacc[2*DATA_W-1:DATA_W] | opa;
      OP_XOR: res[2*DATA_W-1:DATA_W] = dacc[2*DATA_W-1:DATA_W] ^ opa;
      OP_ASR, OP_ASL:
        res = {{GUARD_W{shv[DATA_W-1]}}, shv, {DATA_W{1'b0}}};
      OP_ACCR: res = {dacc[AW-1], dacc[AW-1:1]};
      default: res_upd = 1'b0;
    endcase
  end

  // next state: op result first, field write on top
  always_comb begin
    xr_n  = xr_q;
    acc_n = acc_q;
    ovf_n = ovf_q;
    if (op_valid && res_upd) begin
      acc_n[op_dst] = res;
      ovf_n         = res_ovf;
    end
    if (wr_en) begin
      if (wr_sel[3:2] == 2'd0) begin
        case (wr_sel[1:0])
          2'd0:    xr_n[0] = wr_data;
          2'd1:    xr_n[1] = wr_data;
          2'd2:    xr_n[2] = wr_data;
          default: ;
        endcase
      end else if (wr_sel[3:2] != 2'd3) begin
        case (wr_sel[1:0])
          FLD_LO:  acc_n[wr_sel[3]][DATA_W-1:0]        = wr_data;
          FLD_HI:  acc_n[wr_sel[3]][2*DATA_W-1:DATA_W] = wr_data;
          FLD_EXT: acc_n[wr_sel[3]][AW-1:2*DATA_W]     = wr_data[GUARD_W-1:0];
          default: ;
        endcase
      end
    end
  end

  assign acc_en = op_valid | wr_en;
  assign xr_en  = wr_en;
  assign ovf_en = op_valid;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      for (int k = 0; k < NREG; k++) xr_q[k]  <= '0;
      for (int k = 0; k < NACC; k++) acc_q[k] <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (xr_en)  xr_q  <= xr_n;
      if (acc_en) acc_q <= acc_n;
      if (ovf_en) ovf_q <= ovf_n;
    end
  end

  // limited read path, one limiter per accumulator
  logic [DATA_W-1:0] lim_word [NACC];
  logic              lim_sat  [NACC];

  for (genvar g = 0; g < NACC; g++) begin : g_lim
    fmac_limit #(.DW(DATA_W), .GW(GUARD_W)) u_lim (
      .acc  (acc_q[g]),
      .word (lim_word[g]),
      .sat  (lim_sat[g])
    );
  end

  assign rd_word = lim_word[rd_sel];
  assign rd_sat  = lim_sat[rd_sel];
  assign acc_a   = acc_q[0];
  assign acc_b   = acc_q[1];
  assign ovf     = ovf_q;

endmodule

// File: rtl/fmac_chk.sv
`timescale 1ns/1ps
module fmac_chk #(
  parameter int DW = 16,
  parameter int GW = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               op_valid,
  input logic [3:0]         op_code,
  input logic               op_dst,
  input logic               wr_en,
  input logic               rd_sel,
  input logic [DW-1:0]      rd_word,
  input logic               rd_sat,
  input logic [2*DW+GW-1:0] acc_a,
  input logic [2*DW+GW-1:0] acc_b,
  input logic               ovf
);

  // R11: a clipped read is one of the two full-scale words
  p_sat_word_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sat |-> (rd_word == {1'b0, {(DW-1){1'b1}}} || rd_word == {1'b1, {(DW-1){1'b0}}}));

  // R11: an unclipped read is the upper word of the picked accumulator
  p_pass_word_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_sat |-> rd_word == (rd_sel ? acc_b[2*DW-1:DW] : acc_a[2*DW-1:DW]));

  // R12: idle cycle holds all state
  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && !wr_en) |=> ($stable(acc_a) && $stable(acc_b) && $stable(ovf)));

  // R10: a plain multiply never overflows
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 4'd0) |=> !ovf);

  // R7: logical ops keep the low word of A
  p_logic_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !wr_en && !op_dst && op_code >= 4'd7 && op_code <= 4'd9)
      |=> acc_a[DW-1:0] == $past(acc_a[DW-1:0]));

endmodule

bind fmac_unit fmac_chk #(.DW(DATA_W), .GW(GUARD_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .op_valid (op_valid),
  .op_code  (op_code),
  .op_dst   (op_dst),
  .wr_en    (wr_en),
  .rd_sel   (rd_sel),
  .rd_word  (rd_word),
  .rd_sat   (rd_sat),
  .acc_a    (acc_a),
  .acc_b    (acc_b),
  .ovf      (ovf)
);

// File: tb/test_fmac_unit.sv
`timescale 1ns/1ps
module test_fmac_unit;

  logic        clk, rst_n;
  logic        op_valid, op_dst, op_frac, wr_en, rd_sel;
  logic [3:0]  op_code, op_shamt, wr_sel;
  logic [1:0]  op_src_a, op_src_b;
  logic [15:0] wr_data, rd_word;
  logic        rd_sat, ovf;
  logic [35:0] acc_a, acc_b;

  int checks = 0;
  int errors = 0;

  logic [15:0] m_x [3];
  logic [35:0] m_acc [2];
  logic        m_ovf;

  fmac_unit i_fmac_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_dst(op_dst), .op_src_a(op_src_a), .op_src_b(op_src_b),
    .op_frac(op_frac), .op_shamt(op_shamt), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_word(rd_word), .rd_sat(rd_sat),
    .acc_a(acc_a), .acc_b(acc_b), .ovf(ovf)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic longint s36(logic [35:0] v);
    return longint'($signed(v));
  endfunction
  function automatic longint s16(logic [15:0] v);
    return longint'($signed(v));
  endfunction
  function automatic logic [35:0] w36(longint v);
    return v[35:0];
  endfunction
  function automatic longint srcv(int s);
    return (s == 3) ? 64'sd0 : s16(m_x[s]);
  endfunction

  function automatic logic [15:0] lim(logic [35:0] v);
    longint s = s36(v);
    if (s > 64'sd2147483647)  return 16'h7FFF;
    if (s < -64'sd2147483648) return 16'h8000;
    return v[31:16];
  endfunction
  function automatic logic limsat(logic [35:0] v);
    longint s = s36(v);
    return (s > 64'sd2147483647) || (s < -64'sd2147483648);
  endfunction

  function automatic string tagc(int c);
    case (c)
      0:        return "R3";
      1, 2:     return "R4";
      3, 4:     return "R5";
      5, 6:     return "R6";
      7, 8, 9:  return "R7";
      10, 11:   return "R8";
      12, 13:   return "R9";
      default:  return "R12";
    endcase
  endfunction

  task automatic chk(string tag, logic [35:0] got, logic [35:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] sel, logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (sel)
      4'd0: m_x[0] = d;
      4'd1: m_x[1] = d;
      4'd2: m_x[2] = d;
      4'd4: m_acc[0][15:0]  = d;
      4'd5: m_acc[0][31:16] = d;
      4'd6: m_acc[0][35:32] = d[3:0];
      4'd8: m_acc[1][15:0]  = d;
      4'd9: m_acc[1][31:16] = d;
      4'd10: m_acc[1][35:32] = d[3:0];
      default: ;
    endcase
  endtask

  task automatic setacc(int k, logic [35:0] v);
    wr(4'(4 + 4*k), v[15:0]);
    wr(4'(5 + 4*k), v[31:16]);
    wr(4'(6 + 4*k), {12'h0, v[35:32]});
  endtask

  task automatic mdl(int code, int d, int sa, int sb, bit fr, int sh);
    longint dv, ov, a, b, p, r, tmp;
    logic [35:0] t;
    bit ar;
    dv = s36(m_acc[d]); ov = s36(m_acc[1-d]);
    a = srcv(sa); b = srcv(sb);
    p = a * b; if (fr) p = p * 2;
    ar = 1'b1; t = m_acc[d];
    case (code)
      0:  begin r = p; ar = 1'b0; end
      1:  r = dv + p;
      2:  r = dv - p;
      3:  r = dv + a * 65536;
      4:  r = dv - a * 65536;
      5:  r = dv + ov;
      6:  r = dv - ov;
      7:  begin t[31:16] = t[31:16] & a[15:0]; r = s36(t); ar = 1'b0; end
      8:  begin t[31:16] = t[31:16] | a[15:0]; r = s36(t); ar = 1'b0; end
      9:  begin t[31:16] = t[31:16] ^ a[15:0]; r = s36(t); ar = 1'b0; end
      10: begin r = (a >>> sh) * 65536; ar = 1'b0; end
      11: begin tmp = a << sh; r = s16(tmp[15:0]) * 65536; ar = 1'b0; end
      12: r = dv * 2;
      13: begin r = dv >>> 1; ar = 1'b0; end
      default: return;
    endcase
    m_ovf = ar && ((r > 64'sd34359738367) || (r < -64'sd34359738368));
    m_acc[d] = w36(r);
  endtask

  task automatic doop(int code, int d, int sa, int sb, bit fr, int sh);
    op_valid = 1'b1; op_code = 4'(code); op_dst = d[0];
    op_src_a = 2'(sa); op_src_b = 2'(sb); op_frac = fr; op_shamt = 4'(sh);
    @(negedge clk);
    op_valid = 1'b0;
    mdl(code, d, sa, sb, fr, sh);
  endtask

  task automatic check_all(string tag);
    chk(tag, acc_a, m_acc[0]);
    chk(tag, acc_b, m_acc[1]);
    chk("R10", {35'h0, ovf}, {35'h0, m_ovf});
    rd_sel = 1'b0; #1;
    chk("R11", {20'h0, rd_word}, {20'h0, lim(m_acc[0])});
    chk("R11", {35'h0, rd_sat}, {35'h0, limsat(m_acc[0])});
    rd_sel = 1'b1; #1;
    chk("R11", {20'h0, rd_word}, {20'h0, lim(m_acc[1])});
    chk("R11", {35'h0, rd_sat}, {35'h0, limsat(m_acc[1])});
  endtask

  logic [15:0] vals [8];
  logic [35:0] avals [6];

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'hFFFF; vals[3] = 16'h7FFF;
    vals[4] = 16'h8000; vals[5] = 16'h4000; vals[6] = 16'hC000; vals[7] = 16'h1234;
    avals[0] = 36'h0_0000_0000; avals[1] = 36'h0_7FFF_FFFF; avals[2] = 36'hF_8000_0000;
    avals[3] = 36'h7_FFFF_FFFF; avals[4] = 36'h8_0000_0000; avals[5] = 36'h0_8000_0000;
    for (int k = 0; k < 3; k++) m_x[k] = '0;
    m_acc[0] = '0; m_acc[1] = '0; m_ovf = 1'b0;
    rst_n = 1'b0; op_valid = 1'b0; op_code = '0; op_dst = 1'b0; op_src_a = '0;
    op_src_b = '0; op_frac = 1'b0; op_shamt = '0; wr_en = 1'b0; wr_sel = '0;
    wr_data = '0; rd_sel = 1'b0;
    repeat (3) @(negedge clk);
    // R1: state during reset
    check_all("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R1");
    // R1: source registers are zero, product of X0*Y0 clears a loaded A
    wr(4'd4, 16'h0001);
    doop(0, 0, 0, 1, 1'b0, 0);
    check_all("R1");

    // R2: individual field writes
    setacc(0, 36'hA_1234_5678);
    chk("R2", acc_a, 36'hA_1234_5678);
    wr(4'd9, 16'hFFFF);
    chk("R2", acc_b, 36'h0_FFFF_0000);
    chk("R2", acc_a, 36'hA_1234_5678);
    wr(4'd3, 16'hDEAD);
    wr(4'd7, 16'hBEEF);
    wr(4'd15, 16'hBEEF);
    check_all("R2");

    // R12: idle with noisy inputs
    op_code = 4'd1; op_dst = 1'b1; wr_sel = 4'd5; wr_data = 16'h5555;
    @(negedge clk);
    check_all("R12");

    // R13: write over op result in the same cycle
    wr(4'd0, 16'h4000);
    wr(4'd1, 16'h4000);
    op_valid = 1'b1; op_code = 4'd0; op_dst = 1'b0; op_src_a = 2'd0;
    op_src_b = 2'd1; op_frac = 1'b1; wr_en = 1'b1; wr_sel = 4'd5; wr_data = 16'h5A5A;
    @(negedge clk);
    op_valid = 1'b0; wr_en = 1'b0;
    mdl(0, 0, 0, 1, 1'b1, 0);
    m_acc[0][31:16] = 16'h5A5A;
    check_all("R13");

    // sweep: every opcode, both modes, operand and accumulator corners
    for (int code = 0; code < 16; code++) begin
      for (int fr = 0; fr < 2; fr++) begin
        for (int i = 0; i < 8; i++) begin
          for (int j = 0; j < 8; j++) begin
            wr(4'd0, vals[i]);
            wr(4'd1, vals[j]);
            wr(4'd2, vals[(i + 3) % 8]);
            setacc(0, avals[(i + j) % 6]);
            setacc(1, avals[(i * 3 + j + 1) % 6]);
            doop(code, (i ^ j) & 1, (j < 4) ? 0 : ((i + j) % 4), (j < 4) ? 1 : (j % 3),
                 fr[0], (i * 2 + j) % 16);
            check_all(tagc(code));
          end
        end
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule